// File: doc/BRIEF.md
# Log-Sine Operator Output Stage

This block produces the output samples of a bank of frequency-modulation synthesis operators, four operators to a channel. A slot sequencer visits one operator slot every `SLOT_CYCLES` clock cycles and cycles through all slots in order. On each visit the slot's phase accumulator takes one step by the supplied increment. The upper ten bits of the new phase select the operator's waveform position. The operator's output is then formed without a multiplier. A half-sine table holds the negative base-2 logarithm of the sine, and the attenuation, also a logarithm, is added to it. An exponent table then returns the sum to the linear domain, using a fractional lookup followed by a shift. The top phase bit picks the sign of the result.

The sequencer shows on its ports which slot is due. The surrounding logic supplies that slot's increment and attenuation, and the channel's 3-bit algorithm code, in the same cycle. Each operator result leaves the block as a tagged pulse. When the fourth operator of a channel completes, the channel sum leaves the block in the same cycle as that operator. The sum uses the subset of operators that the algorithm code selects. While a bypass input is high, the slots of the last channel are not processed: their accumulators hold and they produce no output. This leaves that channel free for a direct sample path outside this block.

Top module: `fm_op_out`

## Requirements
- R1: After reset every phase accumulator is zero, op_valid_o and ch_valid_o are low, op_val_o and ch_val_o are zero, slot_idx_o is 0 and slot_go_o is high in the first cycle.
- R2: slot_go_o is high in one cycle out of every SLOT_CYCLES (6). slot_idx_o advances by one at each clock edge where slot_go_o is high, wrapping from NUM_CH*4-1 to 0, and is otherwise stable. Slot s belongs to channel s/4 as operator position s%4.
- R3: At a service edge the addressed accumulator becomes (acc + inc_i) mod 2^ACC_W, and every other accumulator is unchanged. The operator phase is bits [ACC_W-1:ACC_W-10] of the updated value.
- R4: The log sine value for phase bits [8:0] = a is round(-log2(sin((2a+1)/512 * pi/2)) * 256), an unsigned value with 8 fraction bits.
- R5: With log index L = sine log + atten_i, the magnitude is (4*M) >> (L/256), where M = round(2^(-((L%256)+1)/256) * 2048).
- R6: If sine log + atten_i exceeds 8191, L is clamped to 8191, which gives a magnitude of zero.
- R7: op_val_o is the magnitude when phase bit 9 is clear, and the negated magnitude when it is set (signed two's complement).
- R8: For a slot serviced at clock edge k, op_valid_o is high for exactly the cycle after edge k+2. In that cycle op_slot_o holds the slot number and op_val_o holds the result.
- R9: ch_valid_o rises together with op_valid_o for operator position 3, with ch_idx_o = slot/4. The value of ch_val_o depends on the algorithm code. Codes 0 to 3 give operator 3 alone. Code 4 gives operators 1 + 3. Codes 5 and 6 give operators 1 + 2 + 3. Code 7 gives all four.
- R10: While last_ch_bypass_i is high at a service edge for a slot of the last channel, that slot's accumulator holds and no operator or channel output is produced for it.
- R11: The algorithm code used for a channel sum is the alg_i value sampled at the service edge of that channel's operator position 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_i | input | ACC_W | Phase increment for the slot named by slot_idx_o |
| atten_i | input | ATT_W | Log attenuation (8 fraction bits) for that slot |
| alg_i | input | 3 | Algorithm code of that slot's channel |
| last_ch_bypass_i | input | 1 | Skip processing of the last channel's slots |
| slot_go_o | output | 1 | High in the cycle whose closing edge services a slot |
| slot_idx_o | output | SLOT_W | Slot due for service |
| op_valid_o | output | 1 | Operator result pulse |
| op_slot_o | output | SLOT_W | Slot of the operator result |
| op_val_o | output | OUT_W | Signed operator output |
| ch_valid_o | output | 1 | Channel sum pulse |
| ch_idx_o | output | SLOT_W-2 | Channel of the sum |
| ch_val_o | output | OUT_W+2 | Signed channel sum |

## Verification
The bench drives attenuation values that push the log index past its top entry. A design that wrapped the index instead of clamping it would return a loud sample where silence belongs. Phase increments near the full accumulator range force wrap-around and frequent sign flips. A wrong half-cycle bit or a dropped carry would show up as a mirrored or drifting waveform. Every algorithm code, including the two codes that share a subset, is compared against a reference sum. The bypass is switched on and off to show that the last channel's phase resumes exactly where it stopped, rather than running on or being cleared.

// File: rtl/fm_op_pkg.sv
package fm_op_pkg;
   localparam int  OPS_PER_CH = 4;
   localparam real HALF_PI    = 1.5707963267948966;
   localparam int  ALG_W      = 3;
endpackage

// File: rtl/fm_slot_seq.sv
module fm_slot_seq #(
   parameter int NUM_SLOTS   = 24,
   parameter int SLOT_CYCLES = 6,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int CNT_W  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   output logic              go_o,
   output logic [SLOT_W-1:0] slot_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         slot_o <= '0;
      end else begin
         cnt_q <= (cnt_q == CNT_W'(SLOT_CYCLES - 1)) ? '0 : cnt_q + 1'b1;
         if (go_o)
            slot_o <= (slot_o == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_o + 1'b1;
      end
   end

   assign go_o = (cnt_q == '0);

   a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
      slot_o < SLOT_W'(NUM_SLOTS));
   a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
      !go_o |=> $stable(slot_o));
   if (SLOT_CYCLES > 1) begin : g_gap
      a_r2_go_gap: assert property (@(posedge clk) disable iff (rst)
         go_o |=> !go_o);
   end
endmodule

// File: rtl/fm_phase_bank.sv
module fm_phase_bank #(
   parameter int NUM_SLOTS = 24,
   parameter int ACC_W     = 20,
   parameter int PH_W      = 10,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_i,
   input  logic [SLOT_W-1:0] sel_i,
   input  logic [ACC_W-1:0]  inc_i,
   output logic [PH_W-1:0]   phase_o
);
   logic [ACC_W-1:0] acc_q [NUM_SLOTS];
   logic [ACC_W-1:0] acc_nx;

   assign acc_nx  = acc_q[sel_i] + inc_i;
   assign phase_o = acc_nx[ACC_W-1 -: PH_W];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_acc
      always_ff @(posedge clk) begin
         if (rst)
            acc_q[g] <= '0;
         else if (en_i && sel_i == SLOT_W'(g))
            acc_q[g] <= acc_nx;
      end
      a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
         !(en_i && sel_i == SLOT_W'(g)) |=> $stable(acc_q[g]));
   end
endmodule

// File: rtl/fm_logsin_rom.sv
module fm_logsin_rom #(
   parameter int PH_W   = 10,
   parameter int FRAC_W = 8,
   parameter int LOG_W  = 12,
   localparam int N = 2 ** (PH_W - 1)
) (
   input  logic [PH_W-2:0]  addr_i,
   output logic [LOG_W-1:0] val_o
);
   logic [LOG_W-1:0] tbl [N];

   for (genvar g = 0; g < N; g++) begin : g_ent
      localparam real ANG = (2.0 * g + 1.0) / real'(N) * fm_op_pkg::HALF_PI;
      localparam int  ENT = $rtoi(-$ln($sin(ANG)) / $ln(2.0) * real'(2 ** FRAC_W) + 0.5);
      if (g == 0 && ENT >= 2 ** LOG_W) begin : g_bad
         $error("log sine entry does not fit LOG_W");
      end
      assign tbl[g] = LOG_W'(ENT);
   end

   assign val_o = tbl[addr_i];
endmodule

// File: rtl/fm_exp_conv.sv
module fm_exp_conv #(
   parameter int FRAC_W = 8,
   parameter int MANT_W = 11,
   parameter int IDX_W  = 13,
   localparam int N     = 2 ** FRAC_W,
   localparam int SH_W  = IDX_W - FRAC_W,
   localparam int MAG_W = MANT_W + 2
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [MAG_W-1:0] mag_o
);
   logic [MANT_W-1:0] tbl [N];
   logic [MANT_W-1:0] mant;
   logic [SH_W-1:0]   sh;

   for (genvar g = 0; g < N; g++) begin : g_ent
      localparam int ENT = $rtoi($pow(2.0, -(real'(g) + 1.0) / real'(N)) * real'(2 ** MANT_W) + 0.5);
      assign tbl[g] = MANT_W'(ENT);
   end

   assign mant  = tbl[idx_i[FRAC_W-1:0]];
   assign sh    = idx_i[IDX_W-1:FRAC_W];
   // integer part 0 and 1 shift left, 2 is unity, above shifts right
   assign mag_o = {mant, 2'b00} >> sh;
endmodule

// File: rtl/fm_alg_mix.sv
module fm_alg_mix #(
   parameter int OP_W = 14,
   parameter int CH_W = 16
) (
   input  logic [fm_op_pkg::ALG_W-1:0] alg_i,
   input  logic signed [OP_W-1:0]      op_i [fm_op_pkg::OPS_PER_CH],
   output logic signed [CH_W-1:0]      sum_o
);
   logic signed [CH_W-1:0] ext [fm_op_pkg::OPS_PER_CH];

   for (genvar g = 0; g < fm_op_pkg::OPS_PER_CH; g++) begin : g_ext
      assign ext[g] = CH_W'(op_i[g]);
   end

   always_comb begin
      case (alg_i)
         3'd4:       sum_o = ext[1] + ext[3];
         3'd5, 3'd6: sum_o = ext[1] + ext[2] + ext[3];
         3'd7:       sum_o = ext[0] + ext[1] + ext[2] + ext[3];
         default:    sum_o = ext[3];
      endcase
   end
endmodule

// File: rtl/fm_op_out.sv
module fm_op_out #(
   parameter int NUM_CH      = 6,
   parameter int ACC_W       = 20,
   parameter int PH_W        = 10,
   parameter int ATT_W       = 13,
   parameter int FRAC_W      = 8,
   parameter int MANT_W      = 11,
   parameter int SHIFT_W     = 5,
   parameter int SLOT_CYCLES = 6,
   localparam int NUM_SLOTS = NUM_CH * fm_op_pkg::OPS_PER_CH,
   localparam int SLOT_W    = $clog2(NUM_SLOTS),
   localparam int LOG_W     = FRAC_W + 4,
   localparam int IDX_W     = FRAC_W + SHIFT_W,
   localparam int SUM_W     = ((LOG_W > ATT_W) ? LOG_W : ATT_W) + 1,
   localparam int MAG_W     = MANT_W + 2,
   localparam int OUT_W     = MAG_W + 1,
   localparam int CH_W      = OUT_W + 2,
   localparam int LAST_BASE = (NUM_CH - 1) * fm_op_pkg::OPS_PER_CH
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ACC_W-1:0]        inc_i,
   input  logic [ATT_W-1:0]        atten_i,
   input  logic [2:0]              alg_i,
   input  logic                    last_ch_bypass_i,
   output logic                    slot_go_o,
   output logic [SLOT_W-1:0]       slot_idx_o,
   output logic                    op_valid_o,
   output logic [SLOT_W-1:0]       op_slot_o,
   output logic signed [OUT_W-1:0] op_val_o,
   output logic                    ch_valid_o,
   output logic [SLOT_W-3:0]       ch_idx_o,
   output logic signed [CH_W-1:0]  ch_val_o
);
   if (NUM_CH < 2)                  begin : g_chk_ch  $error("NUM_CH must be at least 2"); end
   if (ACC_W < PH_W)                begin : g_chk_acc $error("ACC_W narrower than PH_W"); end
   if (2 ** SHIFT_W - 1 < MAG_W)    begin : g_chk_sh  $error("SHIFT_W cannot reach silence"); end

   // slot sequencing and phase step
   logic              svc;
   logic [PH_W-1:0]   phase;

   fm_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) seq_i (
      .clk(clk), .rst(rst), .go_o(slot_go_o), .slot_o(slot_idx_o));

   assign svc = slot_go_o && !(last_ch_bypass_i && slot_idx_o >= SLOT_W'(LAST_BASE));

   fm_phase_bank #(.NUM_SLOTS(NUM_SLOTS), .ACC_W(ACC_W), .PH_W(PH_W)) bank_i (
      .clk(clk), .rst(rst), .en_i(svc), .sel_i(slot_idx_o), .inc_i(inc_i), .phase_o(phase));

   // stage 1: phase and attenuation captured
   logic              v1;
   logic [PH_W-1:0]   ph1;
   logic [ATT_W-1:0]  att1;
   logic [SLOT_W-1:0] slot1;
   logic [2:0]        alg1;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1 <= 1'b0; ph1 <= '0; att1 <= '0; slot1 <= '0; alg1 <= '0;
      end else begin
         v1 <= svc; ph1 <= phase; att1 <= atten_i; slot1 <= slot_idx_o; alg1 <= alg_i;
      end
   end

   logic [LOG_W-1:0] sin_log;
   logic [SUM_W-1:0] log_sum;
   logic [IDX_W-1:0] idx_nx;

   fm_logsin_rom #(.PH_W(PH_W), .FRAC_W(FRAC_W), .LOG_W(LOG_W)) sin_i (
      .addr_i(ph1[PH_W-2:0]), .val_o(sin_log));

   assign log_sum = SUM_W'(sin_log) + SUM_W'(att1);

   if (SUM_W > IDX_W) begin : g_sat
      assign idx_nx = (|log_sum[SUM_W-1:IDX_W]) ? '1 : log_sum[IDX_W-1:0];
   end else begin : g_nosat
      assign idx_nx = IDX_W'(log_sum);
   end

   // stage 2: log index captured
   logic              v2;
   logic [IDX_W-1:0]  idx2;
   logic              neg2;
   logic [SLOT_W-1:0] slot2;
   logic [2:0]        alg2;

   always_ff @(posedge clk) begin
      if (rst) begin
         v2 <= 1'b0; idx2 <= '0; neg2 <= 1'b0; slot2 <= '0; alg2 <= '0;
      end else begin
         v2 <= v1; idx2 <= idx_nx; neg2 <= ph1[PH_W-1]; slot2 <= slot1; alg2 <= alg1;
      end
   end

   logic [MAG_W-1:0]        mag;
   logic signed [OUT_W-1:0] mag_s, op_nx;
   logic signed [OUT_W-1:0] op_q [fm_op_pkg::OPS_PER_CH-1];
   logic signed [OUT_W-1:0] op_set [fm_op_pkg::OPS_PER_CH];
   logic signed [CH_W-1:0]  ch_nx;
   logic                    last_op;

   fm_exp_conv #(.FRAC_W(FRAC_W), .MANT_W(MANT_W), .IDX_W(IDX_W)) exp_i (
      .idx_i(idx2), .mag_o(mag));

   assign mag_s   = signed'({1'b0, mag});
   assign op_nx   = neg2 ? -mag_s : mag_s;
   assign last_op = (slot2[1:0] == 2'd3);

   for (genvar g = 0; g < fm_op_pkg::OPS_PER_CH - 1; g++) begin : g_opq
      always_ff @(posedge clk) begin
         if (rst)
            op_q[g] <= '0;
         else if (v2 && slot2[1:0] == 2'(g))
            op_q[g] <= op_nx;
      end
      assign op_set[g] = op_q[g];
   end
   assign op_set[fm_op_pkg::OPS_PER_CH-1] = op_nx;

   fm_alg_mix #(.OP_W(OUT_W), .CH_W(CH_W)) mix_i (
      .alg_i(alg2), .op_i(op_set), .sum_o(ch_nx));

   // output stage
   always_ff @(posedge clk) begin
      if (rst) begin
         op_valid_o <= 1'b0; op_slot_o <= '0; op_val_o <= '0;
         ch_valid_o <= 1'b0; ch_idx_o  <= '0; ch_val_o <= '0;
      end else begin
         op_valid_o <= v2;
         ch_valid_o <= v2 && last_op;
         if (v2) begin
            op_slot_o <= slot2;
            op_val_o  <= op_nx;
         end
         if (v2 && last_op) begin
            ch_idx_o <= slot2[SLOT_W-1:2];
            ch_val_o <= ch_nx;
         end
      end
   end

   a_r8_latency: assert property (@(posedge clk) disable iff (rst)
      op_valid_o |-> $past(svc, 3));
   a_r10_bypass_skip: assert property (@(posedge clk) disable iff (rst)
      (op_valid_o && op_slot_o >= SLOT_W'(LAST_BASE)) |-> !$past(last_ch_bypass_i, 3));
   a_r9_ch_with_last: assert property (@(posedge clk) disable iff (rst)
      ch_valid_o |-> (op_valid_o && op_slot_o[1:0] == 2'd3 && ch_idx_o == op_slot_o[SLOT_W-1:2]));
   a_r6_sat_silent: assert property (@(posedge clk) disable iff (rst)
      (v2 && &idx2) |-> (mag == '0));
   a_r7_sign_follow: assert property (@(posedge clk) disable iff (rst)
      (v2 && mag != '0) |=> ((op_val_o < 0) == $past(neg2)));
endmodule

// File: tb/fm_op_out_tb.sv
module fm_op_out_tb_top;
   localparam int NCH = 6, NSL = 24, ACCW = 20, SLCYC = 6, LASTB = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [ACCW-1:0] inc_i = '0;
   logic [12:0] atten_i = '0;
   logic [2:0]  alg_i = '0;
   logic        byp = 1'b0;
   logic        slot_go_o, op_valid_o, ch_valid_o;
   logic [4:0]  slot_idx_o, op_slot_o;
   logic [2:0]  ch_idx_o;
   logic signed [13:0] op_val_o;
   logic signed [15:0] ch_val_o;

   fm_op_out dut_i (
      .clk(clk), .rst(rst), .inc_i(inc_i), .atten_i(atten_i), .alg_i(alg_i),
      .last_ch_bypass_i(byp), .slot_go_o(slot_go_o), .slot_idx_o(slot_idx_o),
      .op_valid_o(op_valid_o), .op_slot_o(op_slot_o), .op_val_o(op_val_o),
      .ch_valid_o(ch_valid_o), .ch_idx_o(ch_idx_o), .ch_val_o(ch_val_o));

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   int tb_inc [NSL];
   int tb_att [NSL];
   int tb_alg [NCH];
   bit tb_byp;

   int m_acc [NSL];
   int m_op  [NSL];
   int m_cnt = 0, m_slot = 0, cyc = 0;

   bit    ev_v [8];
   int    ev_slot [8], ev_val [8];
   string ev_tag [8];
   bit    ev_chv [8];
   int    ev_ch [8], ev_chval [8];

   task automatic chk(bit ok, string tag, string what, int got, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
      end
   endtask

   function automatic int op_model(int acc, int att, output bit sat, output bit neg);
      int  ph  = (acc >> (ACCW - 10)) & 1023;
      int  a   = ph % 512;
      real ang = (2.0 * a + 1.0) / 512.0 * fm_op_pkg::HALF_PI;
      int  s   = $rtoi(-$ln($sin(ang)) / $ln(2.0) * 256.0 + 0.5);
      int  idx = s + att;
      int  f, hi, m, mag;
      sat = (idx > 8191);
      if (sat) idx = 8191;
      f   = idx % 256;
      hi  = idx / 256;
      m   = $rtoi($pow(2.0, -(f + 1.0) / 256.0) * 2048.0 + 0.5);
      mag = (m * 4) >> hi;
      neg = (ph >= 512);
      return neg ? -mag : mag;
   endfunction

   function automatic int mix_model(int alg, int b);
      case (alg)
         4:       return m_op[b+1] + m_op[b+3];
         5, 6:    return m_op[b+1] + m_op[b+2] + m_op[b+3];
         7:       return m_op[b] + m_op[b+1] + m_op[b+2] + m_op[b+3];
         default: return m_op[b+3];
      endcase
   endfunction

   task automatic step();
      int ix = cyc % 8;
      chk(op_valid_o === ev_v[ix], ev_v[ix] ? "R8" : "R8 R10", "op_valid_o", int'(op_valid_o), int'(ev_v[ix]));
      if (ev_v[ix]) begin
         chk(int'(op_slot_o) == ev_slot[ix], "R8", "op_slot_o", int'(op_slot_o), ev_slot[ix]);
         chk(int'(op_val_o) == ev_val[ix], ev_tag[ix], "op_val_o", int'(op_val_o), ev_val[ix]);
      end
      chk(ch_valid_o === ev_chv[ix], "R9 R10", "ch_valid_o", int'(ch_valid_o), int'(ev_chv[ix]));
      if (ev_chv[ix]) begin
         chk(int'(ch_idx_o) == ev_ch[ix], "R9", "ch_idx_o", int'(ch_idx_o), ev_ch[ix]);
         chk(int'(ch_val_o) == ev_chval[ix], "R9 R11", "ch_val_o", int'(ch_val_o), ev_chval[ix]);
      end
      ev_v[ix] = 0;
      ev_chv[ix] = 0;
      chk(slot_go_o === (m_cnt == 0), "R2", "slot_go_o", int'(slot_go_o), int'(m_cnt == 0));
      chk(int'(slot_idx_o) == m_slot, "R2", "slot_idx_o", int'(slot_idx_o), m_slot);
      inc_i   = ACCW'(tb_inc[m_slot]);
      atten_i = 13'(tb_att[m_slot]);
      alg_i   = 3'(tb_alg[m_slot / 4]);
      byp     = tb_byp;
      if (m_cnt == 0) begin
         if (!(tb_byp && m_slot >= LASTB)) begin
            int j = (cyc + 3) % 8;
            bit sat, neg;
            m_acc[m_slot] = (m_acc[m_slot] + tb_inc[m_slot]) & ((1 << ACCW) - 1);
            m_op[m_slot]  = op_model(m_acc[m_slot], tb_att[m_slot], sat, neg);
            ev_v[j] = 1;
            ev_slot[j] = m_slot;
            ev_val[j] = m_op[m_slot];
            ev_tag[j] = $sformatf("R3 R4 R5%s%s", sat ? " R6" : "", neg ? " R7" : "");
            if (m_slot % 4 == 3) begin
               ev_chv[j] = 1;
               ev_ch[j] = m_slot / 4;
               ev_chval[j] = mix_model(tb_alg[m_slot / 4], m_slot - 3);
            end
         end
         m_slot = (m_slot + 1) % NSL;
      end
      m_cnt = (m_cnt + 1) % SLCYC;
      cyc++;
      @(negedge clk);
   endtask

   task automatic set_pattern(int p);
      for (int s = 0; s < NSL; s++) begin
         tb_inc[s] = (s * 40503 + p * 77777 + 9001) & 20'hFFFFF;
         case (p)
            0: tb_att[s] = 0;
            1: tb_att[s] = s * 150;
            2: tb_att[s] = (s % 3 == 0) ? 8191 : s * 300;
            default: tb_att[s] = (s * 977 + 33) % 8192;
         endcase
      end
      if (p == 3) begin
         tb_inc[5] = 20'hFFFFF;    // wrap every step (R3)
         tb_inc[22] = 20'h80000;   // half-cycle flip each visit (R7)
      end
      for (int c = 0; c < NCH; c++)
         case (p)
            0: tb_alg[c] = c;
            1: tb_alg[c] = c + 2;
            2: tb_alg[c] = 7 - c;
            default: tb_alg[c] = (c * 3 + 1) % 8;
         endcase
      tb_byp = (p == 2);
   endtask

   initial begin
      for (int s = 0; s < NSL; s++) begin m_acc[s] = 0; m_op[s] = 0; end
      for (int k = 0; k < 8; k++) begin ev_v[k] = 0; ev_chv[k] = 0; end
      set_pattern(0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(op_valid_o === 1'b0, "R1", "op_valid_o", int'(op_valid_o), 0);
      chk(ch_valid_o === 1'b0, "R1", "ch_valid_o", int'(ch_valid_o), 0);
      chk(op_val_o === '0, "R1", "op_val_o", int'(op_val_o), 0);
      chk(ch_val_o === '0, "R1", "ch_val_o", int'(ch_val_o), 0);
      chk(slot_go_o === 1'b1, "R1", "slot_go_o", int'(slot_go_o), 1);
      chk(slot_idx_o === '0, "R1", "slot_idx_o", int'(slot_idx_o), 0);
      for (int p = 0; p < 5; p++) begin
         set_pattern(p == 4 ? 1 : p);
         repeat (2 * NSL * SLCYC) step();
      end
      repeat (8) step();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule